// File: doc/BRIEF.md
# Three-Step-Per-Round 64-bit Lightweight Block Cipher Core

This core encrypts one 64-bit block under an 80-bit key with the KATAN64 construction. The state lives in two nonlinear feedback shift registers: an upper one of 25 bits and a lower one of 39 bits. An 80-bit key shift register and an 8-bit irregular-update sequence generator feed them. Every clock cycle completes one whole round. A round holds three back-to-back nonlinear update steps. All three use the same pair of key bits and are evaluated together as combinational logic.

The user places the plaintext and key on the inputs and pulses `start` while the core is idle. After 254 round cycles the `done` output pulses for one cycle. The ciphertext then appears on `ciphertext` and stays there until the next accepted start. A synchronous reset aborts any run in progress.

Top module: `katan64_core`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `done` is 0 and `ciphertext` is all zeros.
- R2: A start accepted when idle loads plaintext bits 63..39 into the upper register (bit 39 into its position 0) and bits 38..0 into the lower register. The ciphertext is read back in the same arrangement.
- R3: Each nonlinear step computes two bits. The first is a = U[24]^U[15]^(U[20]&U[11])^(U[9]&ir)^ka; it enters the lower register. The second is b = L[38]^L[25]^(L[33]&L[21])^(L[14]&L[9])^kb; it enters the upper register. Both registers then shift one place toward their top bit, dropping that bit. A round applies this step three times in sequence with the same ka, kb and ir.
- R4: The key register starts as the key with key bit 0 at position 0. Each round takes ka from position 0 and kb from position 1. The register is then advanced twice, each time appending k_i = k_(i-80)^k_(i-61)^k_(i-50)^k_(i-13) at the top.
- R5: The ir bit of a round is bit 7 of an 8-bit sequence register. That register is set to all ones at start and, after each round, shifts left with new bit 0 = s7^s6^s4^s2.
- R6: After the load edge, `done` is high exactly on the cycle following the 254th round edge, and for one cycle only.
- R7: A `start` pulse during a run is ignored: the run keeps its timing and its result.
- R8: When idle, the ciphertext holds its value until the next accepted start.
- R9: A synchronous reset during a run returns the core to idle. No `done` follows and the ciphertext reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an encryption (honoured only when idle) |
| plaintext | input | 64 | Block to encrypt, sampled on the accepted start |
| key | input | 80 | Cipher key, sampled on the accepted start |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext | output | 64 | Register state, upper register in bits 63..39 |

## Verification
The bench runs all-zero, all-one and mixed plaintext/key pairs against a bit-serial model. That model shifts one bit at a time and draws key bits from an unrolled key stream. A core that mixed up the triad offsets, applied the key pair per step instead of per round, or advanced the key register only once would give a wrong ciphertext. The bench counts cycles to `done`, so an off-by-one round count shows up as a latency of 253 or 255. Further directed runs cover three cases: a start during a run, which a faulty core would restart on; an idle period, during which a faulty core would drift; and a reset mid-run, after which a faulty core would still raise `done`.

// File: rtl/katan64_pkg.sv
package katan64_pkg;
  localparam int UP_W  = 25;
  localparam int LO_W  = 39;
  localparam int BLK_W = UP_W + LO_W;
  localparam int KEY_W = 80;
  localparam int IRS_W = 8;

  // Upper-register nonlinear bit for the step at triad offset j.
  function automatic logic up_nl(input logic [UP_W-1:0] u, input int j,
                                 input logic ir, input logic ka);
    return u[24-j] ^ u[15-j] ^ (u[20-j] & u[11-j]) ^ (u[9-j] & ir) ^ ka;
  endfunction

  // Lower-register nonlinear bit for the step at triad offset j.
  function automatic logic lo_nl(input logic [LO_W-1:0] l, input int j,
                                 input logic kb);
    return l[38-j] ^ l[25-j] ^ (l[33-j] & l[21-j]) ^ (l[14-j] & l[9-j]) ^ kb;
  endfunction

  // Two key-register clocks per round.
  function automatic logic [KEY_W-1:0] key_adv2(input logic [KEY_W-1:0] k);
    logic [KEY_W-1:0] r;
    r = k;
    for (int s = 0; s < 2; s++) r = {r[0] ^ r[19] ^ r[30] ^ r[67], r[KEY_W-1:1]};
    return r;
  endfunction

  // Irregular-update sequence step.
  function automatic logic [IRS_W-1:0] irs_adv(input logic [IRS_W-1:0] s);
    return {s[6:0], s[7] ^ s[6] ^ s[4] ^ s[2]};
  endfunction
endpackage

// File: rtl/katan64_ctrl.sv
module katan64_ctrl
  import katan64_pkg::*;
#(
  parameter int ROUNDS = 254
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic ir,
  output logic done
);
  localparam int CW = $clog2(ROUNDS);

  logic             busy_q;
  logic [CW-1:0]    cnt_q;
  logic [IRS_W-1:0] irs_q;
  logic             last_round;

  assign load       = start && !busy_q;
  assign step       = busy_q;
  assign last_round = busy_q && (cnt_q == CW'(ROUNDS - 1));
  assign ir         = irs_q[IRS_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      irs_q  <= '1;
      done   <= 1'b0;
    end else begin
      done <= last_round;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        irs_q  <= '1;
      end else if (busy_q) begin
        irs_q <= irs_adv(irs_q);
        if (last_round) busy_q <= 1'b0;
        else            cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    last_round |=> done);
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !last_round) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));
  // R5
  irs_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (irs_q != '0));
  // R9
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy_q && !done));
endmodule

// File: rtl/katan64_keysched.sv
module katan64_keysched
  import katan64_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [KEY_W-1:0] key,
  output logic             ka,
  output logic             kb
);
  logic [KEY_W-1:0] key_q;

  assign ka = key_q[0];
  assign kb = key_q[1];

  always_ff @(posedge clk) begin
    if (rst)       key_q <= '0;
    else if (load) key_q <= key;
    else if (step) key_q <= key_adv2(key_q);
  end

  // R4
  key_shift_two_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (key_q[KEY_W-3:0] == $past(key_q[KEY_W-1:2])));
endmodule

// File: rtl/katan64_state.sv
module katan64_state
  import katan64_pkg::*;
#(
  parameter int STEPS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [BLK_W-1:0] plaintext,
  input  logic             ka,
  input  logic             kb,
  input  logic             ir,
  output logic [BLK_W-1:0] ciphertext
);
  logic [UP_W-1:0]  up_q;
  logic [LO_W-1:0]  lo_q;
  logic [STEPS-1:0] to_lo;   // oldest step in the top bit
  logic [STEPS-1:0] to_up;

  for (genvar j = 0; j < STEPS; j++) begin : g_triad
    assign to_lo[STEPS-1-j] = up_nl(up_q, j, ir, ka);
    assign to_up[STEPS-1-j] = lo_nl(lo_q, j, kb);
  end

  assign ciphertext = {up_q, lo_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= '0;
      lo_q <= '0;
    end else if (load) begin
      up_q <= plaintext[BLK_W-1:LO_W];
      lo_q <= plaintext[LO_W-1:0];
    end else if (step) begin
      up_q <= {up_q[UP_W-1-STEPS:0], to_up};
      lo_q <= {lo_q[LO_W-1-STEPS:0], to_lo};
    end
  end

  // R3
  up_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (up_q[UP_W-1:STEPS] == $past(up_q[UP_W-1-STEPS:0])));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(ciphertext));
endmodule

// File: rtl/katan64_core.sv
module katan64_core
  import katan64_pkg::*;
#(
  parameter int ROUNDS = 254,
  parameter int STEPS  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [63:0]       plaintext,
  input  logic [79:0]       key,
  output logic              done,
  output logic [63:0]       ciphertext
);
  logic load, step, ir, ka, kb;

  katan64_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .ir(ir), .done(done)
  );

  katan64_keysched u_key (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .key(key), .ka(ka), .kb(kb)
  );

  katan64_state #(.STEPS(STEPS)) u_state (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .plaintext(plaintext), .ka(ka), .kb(kb), .ir(ir),
    .ciphertext(ciphertext)
  );
endmodule

// File: tb/katan64_core_tb.sv
module katan64_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NROUNDS    = 254;
  localparam int NVEC       = 5;
  localparam logic [143:0] VECS [NVEC] = '{
    {64'h0000_0000_0000_0000, 80'h0000_0000_0000_0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 80'hFFFF_FFFF_FFFF_FFFF_FFFF},
    {64'h0123_4567_89AB_CDEF, 80'h0000_0000_0000_0000_0001},
    {64'h8000_0000_0000_0001, 80'hF0E1_D2C3_B4A5_9687_7869},
    {64'hDEAD_BEEF_0BAD_F00D, 80'h1357_9BDF_0246_8ACE_5A5A}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] plaintext = '0;
  logic [79:0] key = '0;
  logic        done;
  logic [63:0] ciphertext;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  katan64_core u_dut (
    .clk(clk), .rst(rst), .start(start), .plaintext(plaintext),
    .key(key), .done(done), .ciphertext(ciphertext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      report();
    end
  end

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bit-serial model: one shift per step, key bits from an unrolled stream.
  function automatic logic [63:0] model(input logic [63:0] pt, input logic [79:0] k);
    logic       ks [0:2*NROUNDS+1];
    logic [24:0] u;
    logic [38:0] l;
    logic [7:0]  seq;
    logic        fa, fb, irb;
    for (int i = 0; i < 2*NROUNDS + 2; i++)
      ks[i] = (i < 80) ? k[i] : (ks[i-80] ^ ks[i-61] ^ ks[i-50] ^ ks[i-13]);
    u = pt[63:39];
    l = pt[38:0];
    seq = 8'hFF;
    for (int r = 0; r < NROUNDS; r++) begin
      irb = seq[7];
      for (int s = 0; s < 3; s++) begin
        fa = u[24] ^ u[15] ^ (u[20] & u[11]) ^ (u[9] & irb) ^ ks[2*r];
        fb = l[38] ^ l[25] ^ (l[33] & l[21]) ^ (l[14] & l[9]) ^ ks[2*r+1];
        u = {u[23:0], fb};
        l = {l[37:0], fa};
      end
      seq = {seq[6:0], seq[7] ^ seq[6] ^ seq[4] ^ seq[2]};
    end
    return {u, l};
  endfunction

  // Pulse start, return cycles from load edge to done (0 if none within limit).
  task automatic run(input logic [63:0] pt, input logic [79:0] k, input int limit,
                     output int lat);
    @(negedge clk);
    plaintext = pt; key = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      if (done) begin lat = n; break; end
    end
  endtask

  initial begin
    int lat;
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R1: values under reset
    check("R1 done in reset", 80'(done), 80'd0);
    check("R1 ciphertext in reset", 80'(ciphertext), 80'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 done after reset", 80'(done), 80'd0);
    check("R1 ciphertext after reset", 80'(ciphertext), 80'd0);

    // R2 R3 R4 R5 R6: vector table
    for (int v = 0; v < NVEC; v++) begin
      run(VECS[v][143:80], VECS[v][79:0], 400, lat);
      check("R6 latency", 80'(lat), 80'(NROUNDS));
      check("R3 R4 R5 R2 ciphertext", 80'(ciphertext), 80'(model(VECS[v][143:80], VECS[v][79:0])));
      @(negedge clk);
      check("R6 done one cycle", 80'(done), 80'd0);
    end

    // R8: idle hold with changing inputs
    held = ciphertext;
    plaintext = ~plaintext; key = ~key;
    repeat (7) @(negedge clk);
    check("R8 hold while idle", 80'(ciphertext), 80'(held));
    check("R8 no done while idle", 80'(done), 80'd0);

    // R7: start pulse mid-run is ignored
    fork
      run(64'h1122_3344_5566_7788, 80'hAAAA_5555_AAAA_5555_AAAA, 400, lat);
      begin
        repeat (101) @(negedge clk);
        plaintext = 64'hFFFF_0000_FFFF_0000; key = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    check("R7 latency kept", 80'(lat), 80'(NROUNDS));
    check("R7 result kept", 80'(ciphertext),
          80'(model(64'h1122_3344_5566_7788, 80'hAAAA_5555_AAAA_5555_AAAA)));

    // R9: reset mid-run
    @(negedge clk);
    plaintext = 64'hCAFE_F00D_1234_5678; key = 80'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 ciphertext zero", 80'(ciphertext), 80'd0);
    lat = 0;
    for (int n = 1; n <= 300; n++) begin
      @(negedge clk);
      if (done) lat = n;
    end
    check("R9 no done after abort", 80'(lat), 80'd0);

    // R6 R3: fresh run after abort
    run(64'hCAFE_F00D_1234_5678, 80'h1, 400, lat);
    check("R6 latency after abort", 80'(lat), 80'(NROUNDS));
    check("R3 result after abort", 80'(ciphertext),
          80'(model(64'hCAFE_F00D_1234_5678, 80'h1)));
    report();
  end
endmodule